// File: doc/BRIEF.md
# Chien Search Error Locator

This engine finds the bit positions of errors in one sector of a BCH codeword once software has solved for the error-locator polynomial sigma(x). Software writes the sigma coefficients and a configuration word over a small memory-mapped bus. It then writes the search length, which is the data bits plus the parity bits. The engine then visits one candidate bit position per clock. For each position it evaluates sigma(x) at the matching inverse field element and records every position where the sum is zero.

When the pass ends, a status word reports a done flag and the number of roots. The located positions can be read back as 1-based bit indices. Position p names byte (p-1)/8, bit (p-1)%8. Positions below the data size fall in the data, and the rest fall in the parity bytes. Software accepts the result only when the root count equals the degree of sigma. A smaller count marks the sector as uncorrectable. A stop command ends a pass early. Bit fields of the configuration and status words keep the layout that driver code decodes.

Arithmetic is in GF(2^13) with primitive polynomial x^13+x^4+x^3+x+1 (0x201B), with alpha a root of it. The register byte offsets are:

| Offset | Register |
|---|---|
| 0x000 | configuration |
| 0x004 | length / start |
| 0x008 | stop |
| 0x00C | status |
| 0x040 + 4k | sigma coefficient k, k = 0..24 |
| 0x100 + 4i | location i, i = 0..23 |

Top module: `chien_locator`

## Requirements
- R1: After reset the status, configuration and location registers all read 0 and no search runs.
- R2: The configuration register keeps (coefficient count - 1) in bits 20:16 and the sector-size flag in bit 0 (1 = 1024-byte sector, 0 = 512-byte sector), and reads back what was written in those fields.
- R3: A write of L > 0 to the length register starts a pass over positions 1..L, one position per clock. The done flag (status bit 0) becomes readable on the read issued one cycle after the L-th clock edge following the write, and not on the read before it.
- R4: Position p is reported exactly when sum_k sigma_k * alpha^(-k(p-1)) = 0. Found positions appear in ascending order at the location registers (0x100 + 4i), one 1-based position per register.
- R5: Status bits 12:8 hold the number of roots found in the last pass.
- R6: A read of the status register clears the done flag; the root count stays.
- R7: Coefficient registers with an index above the programmed count take no part in the evaluation.
- R8: The root count saturates at 24. Only the first 24 positions found are kept.
- R9: A write with bit 0 set to the stop register ends a running pass without setting done.
- R10: A length of 0 completes at once, with done set and a root count of 0.
- R11: Roots of sigma that lie beyond the programmed length are not found, so the count can fall below the degree of sigma.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe; data is valid the following cycle |
| bus_addr | input | 10 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |

## Verification
Count saturation is the hardest case to reach from the ports, because a real sigma of degree at most 24 never has more than 24 roots. The bench writes an all-zero sigma with a coefficient count of one, which makes every position a root. It then checks that the count stops at 24 and that locations 1..24 are kept. The bench also drives errors placed at the first and last searched positions, and roots placed beyond the length. It writes non-zero coefficients above the programmed count. It issues a stop in the middle of a long pass and a read timed to the exact cycle that done rises. A scoreboard computes sigma from known error sets in its own field arithmetic.

// File: rtl/chien_pkg.sv
// Package: field arithmetic helpers and register word indices shared by
// the locator blocks. Assumes field widths of at most 16 bits.
package chien_pkg;

    // Register word indices (byte offset / 4)
    localparam int W_CFG  = 0;
    localparam int W_LEN  = 1;
    localparam int W_STOP = 2;
    localparam int W_STAT = 3;
    localparam int W_SIG  = 16;
    localparam int W_LOC  = 64;

    // Product of two field elements modulo the primitive polynomial
    function automatic logic [15:0] gf_mul(input logic [15:0] a, input logic [15:0] b,
                                           input int m, input logic [16:0] poly);
        logic [15:0] acc;
        logic [16:0] cur;
        acc = '0;
        cur = {1'b0, a};
        for (int i = 0; i < 16; i++) begin
            if (i < m) begin
                if (b[i]) acc = acc ^ cur[15:0];
                cur = cur << 1;
                if (cur[m]) cur = cur ^ poly;
            end
        end
        return acc;
    endfunction

    // alpha^(-k): the inverse of alpha is (poly + 1) / x
    function automatic logic [15:0] gf_inv_pow(input int k, input int m, input logic [16:0] poly);
        logic [16:0] inv_full;
        logic [15:0] res;
        inv_full = (poly ^ 17'd1) >> 1;
        res = 16'd1;
        for (int i = 0; i < k; i++) res = gf_mul(res, inv_full[15:0], m, poly);
        return res;
    endfunction

endpackage

// File: rtl/chien_regs.sv
// Register file: decodes bus writes into configuration, sigma storage and
// command pulses, and returns a registered read word one cycle after bus_rd.
// Assumes word-aligned byte addresses.
module chien_regs
    import chien_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int M      = 13,
    parameter int NCOEF  = 25,
    parameter int NLOC   = 24,
    parameter int LEN_W  = 14,
    parameter int CNT_W  = 5,
    parameter int IDX_W  = 5
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        bus_wr,
    input  logic                        bus_rd,
    input  logic [ADDR_W-1:0]           bus_addr,
    input  logic [31:0]                 bus_wdata,
    output logic [31:0]                 bus_rdata,
    input  logic                        eng_done,
    input  logic [CNT_W-1:0]            eng_cnt,
    input  logic [NLOC-1:0][LEN_W-1:0]  eng_loc,
    output logic [NCOEF-1:0][M-1:0]     sigma,
    output logic [IDX_W-1:0]            coef_top,
    output logic                        start_pulse,
    output logic [LEN_W-1:0]            start_len,
    output logic                        stop_pulse,
    output logic                        stat_rd
);

    logic [ADDR_W-3:0] widx;
    logic              sector_sel;
    logic [LEN_W-1:0]  len_q;
    logic [31:0]       rd_word;

    assign widx        = bus_addr[ADDR_W-1:2];
    assign start_pulse = bus_wr && (int'(widx) == W_LEN);
    assign start_len   = bus_wdata[LEN_W-1:0];
    assign stop_pulse  = bus_wr && (int'(widx) == W_STOP) && bus_wdata[0];
    assign stat_rd     = bus_rd && (int'(widx) == W_STAT);

    // Configuration and length storage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            coef_top   <= '0;
            sector_sel <= 1'b0;
            len_q      <= '0;
        end else if (bus_wr) begin
            if (int'(widx) == W_CFG) begin
                coef_top   <= bus_wdata[16 +: IDX_W];
                sector_sel <= bus_wdata[0];
            end
            if (int'(widx) == W_LEN) len_q <= bus_wdata[LEN_W-1:0];
        end
    end

    // Sigma coefficient storage, one register per coefficient
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sigma <= '0;
        end else begin
            for (int k = 0; k < NCOEF; k++)
                if (bus_wr && int'(widx) == W_SIG + k) sigma[k] <= bus_wdata[M-1:0];
        end
    end

    // Read word selection
    always_comb begin
        rd_word = '0;
        if (int'(widx) == W_CFG) begin
            rd_word[16 +: IDX_W] = coef_top;
            rd_word[0]           = sector_sel;
        end
        if (int'(widx) == W_LEN)  rd_word[LEN_W-1:0] = len_q;
        if (int'(widx) == W_STAT) begin
            rd_word[8 +: CNT_W] = eng_cnt;
            rd_word[0]          = eng_done;
        end
        for (int k = 0; k < NCOEF; k++)
            if (int'(widx) == W_SIG + k) rd_word[M-1:0] = sigma[k];
        for (int i = 0; i < NLOC; i++)
            if (int'(widx) == W_LOC + i) rd_word[LEN_W-1:0] = eng_loc[i];
    end

    // Registered read data
    always_ff @(posedge clk) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_word;
    end

endmodule

// File: rtl/chien_core.sv
// Search core: holds one term register per sigma coefficient, scaled by
// alpha^(-k) each clock, and tests their sum for zero at positions 1..L.
// Assumes sigma is stable while start_pulse is high; it is copied then.
module chien_core
    import chien_pkg::*;
#(
    parameter int          M     = 13,
    parameter logic [16:0] POLY  = 17'h0201B,
    parameter int          NCOEF = 25,
    parameter int          NLOC  = 24,
    parameter int          LEN_W = 14,
    parameter int          CNT_W = 5,
    parameter int          IDX_W = 5
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        start_pulse,
    input  logic [LEN_W-1:0]            start_len,
    input  logic                        stop_pulse,
    input  logic                        stat_rd,
    input  logic [NCOEF-1:0][M-1:0]     sigma,
    input  logic [IDX_W-1:0]            coef_top,
    output logic                        busy,
    output logic                        done,
    output logic [CNT_W-1:0]            root_cnt,
    output logic [NLOC-1:0][LEN_W-1:0]  loc
);

    logic [NCOEF-1:0][M-1:0] term;
    logic [M-1:0]            sum;
    logic [LEN_W-1:0]        pos;
    logic [LEN_W-1:0]        len_q;
    logic                    hit;
    logic                    last;

    // One constant multiplier per coefficient
    for (genvar k = 0; k < NCOEF; k++) begin : g_term
        localparam logic [15:0] STEP = gf_inv_pow(k, M, POLY);
        logic [15:0] scaled;
        assign scaled = gf_mul(16'(term[k]), STEP, M, POLY);

        // Load on start (inactive coefficients zeroed), scale while searching
        always_ff @(posedge clk) begin
            if (!rst_n)           term[k] <= '0;
            else if (start_pulse) term[k] <= (k <= int'(coef_top)) ? sigma[k] : '0;
            else if (busy)        term[k] <= scaled[M-1:0];
        end
    end

    // Evaluate sigma at the current position
    always_comb begin
        sum = '0;
        for (int k = 0; k < NCOEF; k++) sum = sum ^ term[k];
    end

    assign hit  = busy && (sum == '0);
    assign last = busy && (pos == len_q);

    // Pass control: start, stop, position stepping and done flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            done  <= 1'b0;
            pos   <= '0;
            len_q <= '0;
        end else if (start_pulse) begin
            busy  <= (start_len != '0);
            done  <= (start_len == '0);
            pos   <= LEN_W'(1);
            len_q <= start_len;
        end else if (stop_pulse) begin
            busy <= 1'b0;
        end else begin
            if (busy) pos <= pos + LEN_W'(1);
            if (last) begin
                busy <= 1'b0;
                done <= 1'b1;
            end else if (stat_rd) begin
                done <= 1'b0;
            end
        end
    end

    // Root counting with saturation and location capture
    always_ff @(posedge clk) begin
        if (!rst_n || start_pulse) begin
            root_cnt <= '0;
            loc      <= '0;
        end else if (hit && int'(root_cnt) < NLOC) begin
            for (int i = 0; i < NLOC; i++)
                if (i == int'(root_cnt)) loc[i] <= pos;
            root_cnt <= root_cnt + CNT_W'(1);
        end
    end

endmodule

// File: rtl/chien_locator.sv
// Top: bus register file plus search core. Searches positions 1..L of a
// BCH codeword for roots of sigma(x) in GF(2^M).
module chien_locator #(
    parameter int          ADDR_W = 10,
    parameter int          M      = 13,
    parameter logic [16:0] POLY   = 17'h0201B,
    parameter int          T_MAX  = 24,
    parameter int          LEN_W  = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata
);

    localparam int NCOEF = T_MAX + 1;
    localparam int NLOC  = T_MAX;
    localparam int CNT_W = $clog2(NLOC + 1);
    localparam int IDX_W = $clog2(NCOEF);

    logic [NCOEF-1:0][M-1:0]    sigma;
    logic [IDX_W-1:0]           coef_top;
    logic                       start_pulse;
    logic [LEN_W-1:0]           start_len;
    logic                       stop_pulse;
    logic                       stat_rd;
    logic                       busy;
    logic                       done;
    logic [CNT_W-1:0]           root_cnt;
    logic [NLOC-1:0][LEN_W-1:0] loc;

    chien_regs #(
        .ADDR_W(ADDR_W), .M(M), .NCOEF(NCOEF), .NLOC(NLOC),
        .LEN_W(LEN_W), .CNT_W(CNT_W), .IDX_W(IDX_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .eng_done(done), .eng_cnt(root_cnt), .eng_loc(loc),
        .sigma(sigma), .coef_top(coef_top),
        .start_pulse(start_pulse), .start_len(start_len),
        .stop_pulse(stop_pulse), .stat_rd(stat_rd)
    );

    chien_core #(
        .M(M), .POLY(POLY), .NCOEF(NCOEF), .NLOC(NLOC),
        .LEN_W(LEN_W), .CNT_W(CNT_W), .IDX_W(IDX_W)
    ) u_core (
        .clk(clk), .rst_n(rst_n),
        .start_pulse(start_pulse), .start_len(start_len),
        .stop_pulse(stop_pulse), .stat_rd(stat_rd),
        .sigma(sigma), .coef_top(coef_top),
        .busy(busy), .done(done), .root_cnt(root_cnt), .loc(loc)
    );

endmodule

// File: rtl/chien_locator_chk.sv
// Checker: temporal properties of the locator, bound to the top module.
module chien_locator_chk #(
    parameter int NLOC  = 24,
    parameter int CNT_W = 5,
    parameter int LEN_W = 14
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_pulse,
    input logic [LEN_W-1:0] start_len,
    input logic             stop_pulse,
    input logic             stat_rd,
    input logic             busy,
    input logic             done,
    input logic [CNT_W-1:0] root_cnt
);

    a_r8_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        int'(root_cnt) <= NLOC);

    a_r8_count_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(root_cnt) == NLOC && !start_pulse) |=> int'(root_cnt) == NLOC);

    a_r3_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    a_r9_stop_halts: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_pulse && !start_pulse) |=> (!busy && $stable(done)));

    a_r6_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && !busy && !start_pulse) |=> !done);

    a_r10_zero_len: assert property (@(posedge clk) disable iff (!rst_n)
        (start_pulse && start_len == '0) |=> (done && root_cnt == '0));

endmodule

bind chien_locator chien_locator_chk #(.NLOC(NLOC), .CNT_W(CNT_W), .LEN_W(LEN_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .start_pulse(start_pulse), .start_len(start_len),
    .stop_pulse(stop_pulse), .stat_rd(stat_rd), .busy(busy), .done(done),
    .root_cnt(root_cnt)
);

// File: tb/test_chien_locator.sv
module test_chien_locator;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [9:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;

    int checks = 0;
    int errors = 0;
    int    exp_q[$];
    int    act_q[$];
    string lab_q[$];

    localparam int A_CFG = 'h000, A_LEN = 'h004, A_STOP = 'h008, A_STAT = 'h00C;
    localparam int A_SIG = 'h040, A_LOC = 'h100;

    always #4 clk = ~clk;

    chien_locator i_chien_locator (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    // Bench-side field arithmetic, GF(2^13), polynomial 0x201B
    function automatic int bmul(input int a, input int b);
        int acc = 0;
        for (int i = 0; i < 13; i++) begin
            if ((b >> i) & 1) acc ^= a;
            a = a << 1;
            if (a & 'h2000) a ^= 'h201B;
        end
        return acc;
    endfunction

    function automatic int apow(input int e);
        int r = 1;
        for (int i = 0; i < e; i++) r = bmul(r, 2);
        return r;
    endfunction

    // Tasks start and end at a falling edge
    task automatic bus_write(input int addr, input int data);
        bus_addr = 10'(addr); bus_wdata = data; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input int addr, output int data);
        bus_addr = 10'(addr); bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        data = bus_rdata;
    endtask

    // Driver: push the expectation, then produce the actual item
    task automatic expect_reg(input int addr, input int exp, input string lab);
        int v;
        exp_q.push_back(exp);
        lab_q.push_back(lab);
        bus_read(addr, v);
        act_q.push_back(v);
    endtask

    task automatic expect_val(input int act, input int exp, input string lab);
        exp_q.push_back(exp);
        lab_q.push_back(lab);
        act_q.push_back(act);
    endtask

    // Monitor: pop and compare
    initial begin
        forever begin
            @(negedge clk);
            while (act_q.size() > 0 && exp_q.size() > 0) begin
                int a, e;
                string l;
                a = act_q.pop_front(); e = exp_q.pop_front(); l = lab_q.pop_front();
                checks++;
                if (a != e) begin
                    errors++;
                    $display("FAIL %s actual 0x%0h expected 0x%0h", l, a, e);
                end
            end
        end
    end

    task automatic poll_done(output int st);
        int guard = 0;
        st = 0;
        while (((st & 1) == 0) && guard < 20000) begin
            bus_read(A_STAT, st);
            guard++;
        end
    endtask

    // Program sigma for a sorted error set, run, and score the result
    task automatic search(input int errs[$], input int len, input int junk_val, input string lab);
        int c[25];
        int deg = 0;
        int st;
        int found[$];
        for (int k = 0; k < 25; k++) c[k] = 0;
        c[0] = 1;
        foreach (errs[n]) begin
            int x = apow(errs[n] - 1);
            for (int k = deg + 1; k >= 1; k--) c[k] ^= bmul(x, c[k-1]);
            deg++;
        end
        for (int k = 0; k < 25; k++)
            bus_write(A_SIG + 4 * k, (k > deg && junk_val != 0) ? junk_val : c[k]);
        bus_write(A_CFG, (deg << 16) | 1);
        bus_write(A_LEN, len);
        foreach (errs[n]) if (errs[n] <= len && found.size() < 24) found.push_back(errs[n]);
        poll_done(st);
        expect_val(st, (found.size() << 8) | 1, {lab, " R5 status count/done"});
        expect_reg(A_STAT, found.size() << 8, {lab, " R6 done cleared by read"});
        foreach (found[i]) expect_reg(A_LOC + 4 * i, found[i], {lab, " R4 location"});
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int st;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        expect_reg(A_STAT, 0, "R1 status after reset");
        expect_reg(A_CFG, 0, "R1 config after reset");
        expect_reg(A_LOC, 0, "R1 location after reset");

        // R2: configuration fields read back
        bus_write(A_CFG, 32'h0013_0001);
        expect_reg(A_CFG, 32'h0013_0001, "R2 config readback 1024");
        bus_write(A_CFG, 32'h0007_0000);
        expect_reg(A_CFG, 32'h0007_0000, "R2 config readback 512");

        // R4/R5: several error patterns
        search('{5, 77, 300}, 4200, 0, "pattern A");
        search('{1, 512}, 512, 0, "R4 first/last position");
        search('{3, 64, 1000, 2048, 4097, 6000, 7777, 8191}, 8191, 0, "pattern eight");

        // R7: junk above the coefficient count is ignored
        search('{9, 41, 1500}, 2000, 'h1ABC, "R7 junk coefficients");

        // R11: one root beyond the length
        search('{100, 200}, 150, 0, "R11 root past length");

        // R8: zero sigma makes every position a root; count saturates
        for (int k = 0; k < 25; k++) bus_write(A_SIG + 4 * k, 0);
        bus_write(A_CFG, 0);
        bus_write(A_LEN, 40);
        poll_done(st);
        expect_val(st, (24 << 8) | 1, "R8 saturated count");
        expect_reg(A_LOC + 0, 1, "R8 first kept location");
        expect_reg(A_LOC + 4 * 23, 24, "R8 last kept location");

        // R10: zero length completes at once
        bus_write(A_SIG, 1);
        bus_write(A_LEN, 0);
        expect_reg(A_STAT, 1, "R10 zero length done");

        // R3: exact cycle of done (sigma = 1, no roots, L = 50)
        bus_write(A_LEN, 50);
        repeat (49) @(negedge clk);
        expect_reg(A_STAT, 0, "R3 done not yet set");
        expect_reg(A_STAT, 1, "R3 done set");

        // R9: stop a long pass
        bus_write(A_LEN, 8000);
        repeat (10) @(negedge clk);
        bus_write(A_STOP, 1);
        repeat (8100) @(negedge clk);
        expect_reg(A_STAT, 0, "R9 stopped pass never completes");

        // Engine usable after stop
        search('{2}, 16, 0, "R9 after stop");

        repeat (4) @(negedge clk);
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL scoreboard left %0d items", exp_q.size());
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule